// File: doc/BRIEF.md
# Sixteen-Bit ALU with Registered Status Word

The block is the arithmetic and logic stage of a small 16-bit datapath. Each cycle it takes two operands, a 4-bit operation code and the current status word. It returns the result and a write-back enable straight away, in the same cycle, through combinational logic. The updated status word is captured in a register at the next clock edge. The operations are add, add with carry, subtract, subtract with borrow, compare, negate, exclusive-or, load (pass B), OR and AND. A store code passes operand A through as the data to be stored and writes back nothing. Four codes are not supported and are flagged as illegal.

Four bits of the status word are flags: negative in bit 9, zero in bit 8, signed overflow in bit 7 and carry in bit 6. Every other bit of the status word passes from the input word to the register without change. The carry used by the operations that take one in is bit 6 of the input status word. When `op_valid` is low, the registered status word holds its value. It also holds for the store code and for illegal codes.

Top module: `alu16_status_core`

## Requirements
- R1: Code 0 gives A+B. Code 1 gives A+B+Cin, where Cin is bit 6 of `stat_in`. For both, bit 6 of the new status is the carry out of bit 15, and bit 7 is set when A and B have the same sign and the result sign differs from it.
- R2: Codes 2 and 4 give A+~B+1. Code 3 gives A+~B+Cin. Carry and overflow are formed as in R1, using ~B as the second operand.
- R3: Code 6 gives 0-B. Code 8 gives A XOR B. Code 9 gives B. Code 10 gives A OR B. Codes 11 and 12 give A AND B.
- R4: For every code in R1–R3, bit 9 of the new status equals result bit 15, and bit 8 is set exactly when the result is zero.
- R5: For codes 6 and 8 to 12, bits 6 and 7 of the new status are copied from `stat_in`. Only codes 0 to 4 change them.
- R6: `wb_en` is 1 for codes 0–3, 6 and 8–12. It is 0 for code 4 (compare), which still updates the flags.
- R7: Code 13 (store) drives `result` = A and `wb_en` = 0, and leaves `stat_q` unchanged.
- R8: Codes 5, 7, 14 and 15 drive `illegal_op` = 1, `wb_en` = 0 and `result` = 0, and leave `stat_q` unchanged.
- R9: When the status is updated, every bit of `stat_q` other than bits 6 to 9 is copied from `stat_in`.
- R10: After reset, `stat_q` is 0. While `op_valid` is 0, `stat_q` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Apply the operation and allow the status update at this edge |
| op_code | input | 4 | Operation selector |
| opnd_a | input | 16 | First operand (store data for code 13) |
| opnd_b | input | 16 | Second operand |
| stat_in | input | 16 | Current status word; bit 6 is the carry in |
| result | output | 16 | Combinational result |
| wb_en | output | 1 | Combinational write-back enable |
| illegal_op | output | 1 | Combinational unsupported-code flag |
| stat_q | output | 16 | Registered status word |

## Verification
`result`, `wb_en` and `illegal_op` are due in the same cycle as the inputs. The bench samples them 1 ns after it drives the inputs at the falling edge, so they are checked before the next rising edge. `stat_q` is due one rising edge after the operation is presented, so the bench samples it 1 ns after that edge. At that point it compares `stat_q` with a reference status word that the model advances only for valid, flag-updating codes. Directed vectors cover the carry, overflow and zero boundaries, and a random run covers all sixteen codes.

// File: rtl/alu16_pkg.sv
package alu16_pkg;
   localparam logic [3:0] OP_ADD  = 4'd0;
   localparam logic [3:0] OP_ADC  = 4'd1;
   localparam logic [3:0] OP_SUB  = 4'd2;
   localparam logic [3:0] OP_SBC  = 4'd3;
   localparam logic [3:0] OP_CMP  = 4'd4;
   localparam logic [3:0] OP_NEG  = 4'd6;
   localparam logic [3:0] OP_XOR  = 4'd8;
   localparam logic [3:0] OP_LD   = 4'd9;
   localparam logic [3:0] OP_OR   = 4'd10;
   localparam logic [3:0] OP_AND  = 4'd11;
   localparam logic [3:0] OP_AND2 = 4'd12;
   localparam logic [3:0] OP_ST   = 4'd13;

   typedef enum logic [2:0] {
      SEL_SUM, SEL_XOR, SEL_B, SEL_OR, SEL_AND, SEL_A, SEL_ZERO
   } res_sel_e;

   typedef struct packed {
      res_sel_e sel;
      logic     zero_a;
      logic     inv_b;
      logic     cin_one;
      logic     use_cin;
      logic     upd_nz;
      logic     upd_cs;
      logic     wb;
      logic     illegal;
   } dec_t;
endpackage

// File: rtl/alu16_decode.sv
module alu16_decode
   import alu16_pkg::*;
(
   input  logic [3:0] op_code,
   output dec_t       dec
);
   always_comb begin
      dec = '{sel: SEL_ZERO, zero_a: 1'b0, inv_b: 1'b0, cin_one: 1'b0,
              use_cin: 1'b0, upd_nz: 1'b0, upd_cs: 1'b0, wb: 1'b0,
              illegal: 1'b0};
      case (op_code)
         OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
            dec.sel     = SEL_SUM;
            dec.inv_b   = (op_code == OP_SUB) || (op_code == OP_SBC) ||
                          (op_code == OP_CMP);
            dec.cin_one = (op_code == OP_SUB) || (op_code == OP_CMP);
            dec.use_cin = (op_code == OP_ADC) || (op_code == OP_SBC);
            dec.upd_nz  = 1'b1;
            dec.upd_cs  = 1'b1;
            dec.wb      = (op_code != OP_CMP);
         end
         OP_NEG: begin
            dec.sel     = SEL_SUM;
            dec.zero_a  = 1'b1;
            dec.inv_b   = 1'b1;
            dec.cin_one = 1'b1;
            dec.upd_nz  = 1'b1;
            dec.wb      = 1'b1;
         end
         OP_XOR, OP_LD, OP_OR, OP_AND, OP_AND2: begin
            case (op_code)
               OP_XOR:  dec.sel = SEL_XOR;
               OP_LD:   dec.sel = SEL_B;
               OP_OR:   dec.sel = SEL_OR;
               default: dec.sel = SEL_AND;
            endcase
            dec.upd_nz = 1'b1;
            dec.wb     = 1'b1;
         end
         OP_ST:   dec.sel = SEL_A;
         default: dec.illegal = 1'b1;
      endcase
   end
endmodule

// File: rtl/alu16_adder.sv
module alu16_adder #(
   parameter int W      = 16,
   parameter bit RIPPLE = 1'b0
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   output logic [W-1:0] sum,
   output logic         cout
);
   generate
      if (RIPPLE) begin : g_ripple
         logic [W:0] cy;
         assign cy[0] = cin;
         for (genvar i = 0; i < W; i++) begin : g_bit
            assign sum[i]   = a[i] ^ b[i] ^ cy[i];
            assign cy[i+1]  = (a[i] & b[i]) | (cy[i] & (a[i] ^ b[i]));
         end
         assign cout = cy[W];
      end else begin : g_behav
         assign {cout, sum} = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      end
   endgenerate
endmodule

// File: rtl/alu16_resmux.sv
module alu16_resmux
   import alu16_pkg::*;
#(
   parameter int W = 16
) (
   input  res_sel_e     sel,
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic [W-1:0] sum,
   output logic [W-1:0] y
);
   always_comb begin
      case (sel)
         SEL_SUM: y = sum;
         SEL_XOR: y = a ^ b;
         SEL_B:   y = b;
         SEL_OR:  y = a | b;
         SEL_AND: y = a & b;
         SEL_A:   y = a;
         default: y = '0;
      endcase
   end
endmodule

// File: rtl/alu16_status_core.sv
module alu16_status_core
   import alu16_pkg::*;
#(
   parameter int W            = 16,
   parameter int N_POS        = 9,
   parameter int Z_POS        = 8,
   parameter int S_POS        = 7,
   parameter int C_POS        = 6,
   parameter bit ADDER_RIPPLE = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         op_valid,
   input  logic [3:0]   op_code,
   input  logic [W-1:0] opnd_a,
   input  logic [W-1:0] opnd_b,
   input  logic [W-1:0] stat_in,
   output logic [W-1:0] result,
   output logic         wb_en,
   output logic         illegal_op,
   output logic [W-1:0] stat_q
);
   localparam int MSB = W - 1;

   initial begin
      assert (W >= 10) else $fatal(1, "W too small for flag positions");
      assert (N_POS < W && Z_POS < W && S_POS < W && C_POS < W)
         else $fatal(1, "flag position outside status word");
      assert (N_POS != Z_POS && N_POS != S_POS && N_POS != C_POS &&
              Z_POS != S_POS && Z_POS != C_POS && S_POS != C_POS)
         else $fatal(1, "flag positions overlap");
   end

   dec_t         dec;
   logic [W-1:0] add_a, add_b, sum, stat_nxt;
   logic         cin, cout, ovf;

   alu16_decode u_dec (.op_code(op_code), .dec(dec));

   assign add_a = dec.zero_a ? '0 : opnd_a;
   assign add_b = dec.inv_b ? ~opnd_b : opnd_b;
   assign cin   = dec.cin_one | (dec.use_cin & stat_in[C_POS]);

   alu16_adder #(.W(W), .RIPPLE(ADDER_RIPPLE)) u_add (
      .a(add_a), .b(add_b), .cin(cin), .sum(sum), .cout(cout)
   );

   assign ovf = (add_a[MSB] == add_b[MSB]) && (sum[MSB] != add_a[MSB]);

   alu16_resmux #(.W(W)) u_mux (
      .sel(dec.sel), .a(opnd_a), .b(opnd_b), .sum(sum), .y(result)
   );

   assign wb_en      = dec.wb;
   assign illegal_op = dec.illegal;

   always_comb begin
      stat_nxt        = stat_in;
      stat_nxt[N_POS] = result[MSB];
      stat_nxt[Z_POS] = (result == '0);
      if (dec.upd_cs) begin
         stat_nxt[C_POS] = cout;
         stat_nxt[S_POS] = ovf;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      stat_q <= '0;
      else if (op_valid && dec.upd_nz) stat_q <= stat_nxt;
   end
endmodule

// File: rtl/alu16_status_chk.sv
module alu16_status_chk
   import alu16_pkg::*;
#(
   parameter int W     = 16,
   parameter int N_POS = 9,
   parameter int Z_POS = 8,
   parameter int S_POS = 7,
   parameter int C_POS = 6
) (
   input logic         clk,
   input logic         rst_n,
   input logic         op_valid,
   input logic [3:0]   op_code,
   input logic [W-1:0] stat_in,
   input logic [W-1:0] result,
   input logic         wb_en,
   input logic         illegal_op,
   input logic [W-1:0] stat_q
);
   logic flag_op, logic_op;
   assign flag_op  = op_valid && !illegal_op && (op_code != OP_ST);
   assign logic_op = op_valid && (op_code == OP_NEG || (op_code >= OP_XOR && op_code <= OP_AND2));

   // R10
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !op_valid |=> $stable(stat_q));
   // R8
   illegal_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_op |-> !wb_en);
   // R8
   illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && illegal_op |=> $stable(stat_q));
   // R7
   store_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_valid && op_code == OP_ST |=> $stable(stat_q));
   // R4
   n_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_op |=> stat_q[N_POS] == $past(result[W-1]));
   // R4
   z_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flag_op |=> stat_q[Z_POS] == ($past(result) == '0));
   // R5
   cs_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      logic_op |=> stat_q[C_POS] == $past(stat_in[C_POS]) &&
                   stat_q[S_POS] == $past(stat_in[S_POS]));
   // R6
   cmp_no_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_code == OP_CMP |-> !wb_en && !illegal_op);
endmodule

bind alu16_status_core alu16_status_chk #(
   .W(W), .N_POS(N_POS), .Z_POS(Z_POS), .S_POS(S_POS), .C_POS(C_POS)
) u_chk (
   .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
   .stat_in(stat_in), .result(result), .wb_en(wb_en),
   .illegal_op(illegal_op), .stat_q(stat_q)
);

// File: tb/test_alu16_status_core.sv
module test_alu16_status_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [3:0]  op_code = '0;
   logic [15:0] opnd_a = '0, opnd_b = '0, stat_in = '0;
   logic [15:0] result, stat_q;
   logic        wb_en, illegal_op;

   int total = 0;
   int bad = 0;
   logic [15:0] model_stat = '0;

   always #4 clk = ~clk;

   alu16_status_core i_alu16_status_core (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .opnd_a(opnd_a), .opnd_b(opnd_b), .stat_in(stat_in),
      .result(result), .wb_en(wb_en), .illegal_op(illegal_op), .stat_q(stat_q)
   );

   task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic step(string tag, logic v, logic [3:0] o,
                       logic [15:0] a, logic [15:0] b, logic [15:0] s);
      logic [16:0] t;
      logic [15:0] r, bx, ns;
      logic        w, ill, nz, cs, ci;
      @(negedge clk);
      op_valid = v; op_code = o; opnd_a = a; opnd_b = b; stat_in = s;
      ci = s[6]; r = 16'h0; w = 1'b0; ill = 1'b0; nz = 1'b1; cs = 1'b0; bx = b;
      t = 17'h0;
      case (o)
         0:     begin t = a + b;             cs = 1; w = 1; end
         1:     begin t = a + b + ci;        cs = 1; w = 1; end
         2, 4:  begin bx = ~b; t = a + bx + 1;  cs = 1; w = (o == 2); end
         3:     begin bx = ~b; t = a + bx + ci; cs = 1; w = 1; end
         6:     begin t = 17'(16'(0 - b)); w = 1; end
         8:     begin t = 17'(a ^ b); w = 1; end
         9:     begin t = 17'(b);     w = 1; end
         10:    begin t = 17'(a | b); w = 1; end
         11, 12: begin t = 17'(a & b); w = 1; end
         13:    begin t = 17'(a); nz = 0; end
         default: begin ill = 1; nz = 0; end
      endcase
      r = t[15:0];
      #1;
      chk(tag, "result", result, r);
      chk(tag, "wb_en", {15'h0, wb_en}, {15'h0, w});
      chk(tag, "illegal_op", {15'h0, illegal_op}, {15'h0, ill});
      if (v && nz) begin
         ns = s;
         ns[9] = r[15];
         ns[8] = (r == 16'h0);
         if (cs) begin
            ns[6] = t[16];
            ns[7] = (a[15] == bx[15]) && (r[15] != a[15]);
         end
         model_stat = ns;
      end
      @(posedge clk);
      #1;
      chk(tag, "stat_q", stat_q, model_stat);
   endtask

   initial begin
      #(8 * 150000);
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R10", "reset stat_q", stat_q, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;
      // R1 add / add with carry
      step("R1", 1, 0, 16'h7FFF, 16'h0001, 16'h0000);  // overflow, N
      step("R1", 1, 0, 16'hFFFF, 16'h0001, 16'h0000);  // carry, Z
      step("R1", 1, 1, 16'h0001, 16'h0001, 16'h0040);  // 3 with Cin
      step("R1", 1, 1, 16'h1234, 16'h4321, 16'h0000);
      // R2 subtract, compare, borrow
      step("R2", 1, 2, 16'h0005, 16'h0005, 16'h0000);
      step("R2", 1, 4, 16'h8000, 16'h0001, 16'h0000);
      step("R2", 1, 3, 16'h0005, 16'h0003, 16'h0000);
      step("R2", 1, 3, 16'h0005, 16'h0003, 16'h0040);
      step("R2", 1, 2, 16'h0001, 16'h0002, 16'h0000);
      // R3 / R5 logic ops keep C and S from stat_in
      step("R3", 1, 6, 16'h0000, 16'h0001, 16'h00C0);
      step("R3", 1, 6, 16'h0000, 16'h0000, 16'h0000);
      step("R5", 1, 8, 16'hF0F0, 16'h0FF0, 16'h00C0);
      step("R3", 1, 9, 16'h1111, 16'h8000, 16'h0040);
      step("R3", 1, 10, 16'h0000, 16'h0000, 16'h0080);
      step("R3", 1, 11, 16'hFF00, 16'h0FF0, 16'h0000);
      step("R3", 1, 12, 16'h00FF, 16'hFF00, 16'h0000);
      // R4 zero and negative on arithmetic
      step("R4", 1, 0, 16'h8000, 16'h8000, 16'h0000);
      // R9 other status bits preserved
      step("R9", 1, 0, 16'h0001, 16'h0001, 16'hFC3F);
      step("R9", 1, 10, 16'h0001, 16'h0000, 16'hA815);
      // R7 store
      step("R7", 1, 13, 16'hBEEF, 16'h1234, 16'h0000);
      // R8 illegal codes
      step("R8", 1, 5, 16'h0000, 16'h0000, 16'h0000);
      step("R8", 1, 7, 16'hFFFF, 16'hFFFF, 16'h0000);
      step("R8", 1, 14, 16'h8000, 16'h0001, 16'hFFFF);
      step("R8", 1, 15, 16'h0001, 16'h0001, 16'h0000);
      // R10 idle holds
      step("R10", 0, 0, 16'h0000, 16'h0000, 16'h0000);
      step("R10", 0, 2, 16'h0001, 16'h0002, 16'hFFFF);
      // R6 mixed random run over every code
      for (int i = 0; i < 400; i++) begin
         step("R6", 1'($urandom), 4'($urandom), 16'($urandom), 16'($urandom), 16'($urandom));
      end
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule